// File: doc/BRIEF.md
# Extended-Real to Double Converter

This block converts floating-point values between the 80-bit extended real layout and IEEE double precision. The extended layout is carried as two words: a 64-bit significand with an explicit integer bit, and a 16-bit word holding the sign and a 15-bit biased exponent. The block sits on the extended load and store paths of a floating-point unit. The load side widens a double into the extended layout, and the store side narrows an extended value into a double.

Each direction is an independent single-stage pipeline with its own valid input and valid output. Narrowing changes the exponent bias and drops the integer bit. It rounds the 52-bit fraction up when the first discarded significand bit is set, saturates out-of-range exponents to infinity, and flushes exponents below the double range to signed zero. Widening changes the bias back, restores the integer bit and pads the significand with zeros. Both directions pass infinities and NaNs through, and NaNs keep a nonzero fraction.

Top module: `ext_dbl_cvt`

## Requirements
- R1: Each direction produces its result with its valid output high in the cycle after the valid input is sampled, one output pulse per accepted input. While the valid input is low, the data outputs hold their last value and the valid output stays low. After reset both valid outputs and all data outputs are zero.
- R2: Narrowing a finite value with nonzero exponent (extended exponent in bits 14:0 of the high word, bias 16383, sign in bit 15) gives sign in double bit 63, exponent minus 15360 in bits 62:52, and significand bits 62:11 as the fraction in bits 51:0 when significand bit 10 is clear.
- R3: When significand bit 10 is set, narrowing adds one to the fraction. A carry out of the fraction raises the exponent by one and leaves the fraction zero.
- R4: When the re-biased exponent after rounding is 2047 or more, narrowing gives a signed infinity: exponent 0x7FF, fraction zero.
- R5: Narrowing gives a signed zero (only bit 63 may be set) when the extended exponent is 0, or when the re-biased exponent after rounding is 0 or negative.
- R6: Extended exponent 0x7FFF narrows to double exponent 0x7FF with no rounding. If significand bits 62:0 are all zero the fraction is zero (infinity). Otherwise the fraction is significand bits 62:11, replaced by 1 if those bits are all zero.
- R7: Widening a double with exponent 1 to 0x7FE gives high word {sign, exponent + 15360} and significand {1, fraction, eleven zeros}.
- R8: Widening a double with exponent 0, whatever its fraction, gives significand zero and high word {sign, 15'h0}.
- R9: Widening a double with exponent 0x7FF gives extended exponent 0x7FFF and significand {1, fraction, eleven zeros}, so a NaN fraction stays nonzero.
- R10: The two directions run at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nar_valid_i | input | 1 | Narrowing input valid |
| nar_sig_i | input | 64 | Extended significand to narrow |
| nar_hi_i | input | 16 | Extended sign and exponent to narrow |
| nar_valid_o | output | 1 | Narrowing result valid |
| nar_dbl_o | output | 64 | Double result |
| wid_valid_i | input | 1 | Widening input valid |
| wid_dbl_i | input | 64 | Double to widen |
| wid_valid_o | output | 1 | Widening result valid |
| wid_sig_o | output | 64 | Extended significand result |
| wid_hi_o | output | 16 | Extended sign and exponent result |

## Verification
The bench aims at the rounding carry: an all-ones fraction with the round bit set must step the exponent. A design that dropped the carry would return a zero fraction at the old exponent, and the same carry at exponent 0x7FE must give infinity, not a NaN-like 0x7FF with junk. It checks both edges of the exponent range, just inside and just outside. A wrong bias or wrong comparison would let such a value wrap into a small finite number instead of saturating or flushing. A NaN whose payload lies only below bit 11 must not collapse into infinity. Widened zeros and denormals must not get the integer bit set, since that would turn them into nonzero values.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int EXT_EXP_W   = 15;
  localparam int EXT_SIG_W   = 64;
  localparam int DBL_EXP_W   = 11;
  localparam int DBL_FRAC_W  = 52;

  localparam int EXT_HI_W    = 1 + EXT_EXP_W;
  localparam int DBL_W       = 1 + DBL_EXP_W + DBL_FRAC_W;
  localparam int DROP_W      = EXT_SIG_W - 1 - DBL_FRAC_W;
  localparam int EXT_BIAS    = (1 << (EXT_EXP_W - 1)) - 1;
  localparam int DBL_BIAS    = (1 << (DBL_EXP_W - 1)) - 1;
  localparam int BIAS_DELTA  = EXT_BIAS - DBL_BIAS;
  localparam int EXT_EXP_MAX = (1 << EXT_EXP_W) - 1;
  localparam int DBL_EXP_MAX = (1 << DBL_EXP_W) - 1;

  typedef struct packed {
    logic                  sign;
    logic [DBL_EXP_W-1:0]  exp;
    logic [DBL_FRAC_W-1:0] frac;
  } dbl_t;

  typedef struct packed {
    logic                 sign;
    logic [EXT_EXP_W-1:0] exp;
  } ext_hi_t;

  typedef enum logic [1:0] {
    FC_ZERO,
    FC_FINITE,
    FC_INF,
    FC_NAN
  } fclass_e;
endpackage

// File: rtl/cvt_pipe.sv
module cvt_pipe #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/ext_to_dbl.sv
module ext_to_dbl
  import cvt_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [EXT_SIG_W-1:0] sig_i,
  input  logic [EXT_HI_W-1:0]  hi_i,
  output logic                 valid_o,
  output logic [DBL_W-1:0]     dbl_o
);
  localparam int CALC_W = EXT_EXP_W + 2;

  logic                  sign;
  logic [EXT_EXP_W-1:0]  exp_in;
  logic [DBL_FRAC_W-1:0] frac_trunc;
  logic [DBL_FRAC_W:0]   frac_rnd;
  logic [CALC_W-1:0]     exp_adj;
  logic                  adj_neg;
  logic                  adj_zero;
  logic                  adj_ovf;
  logic                  payload_nz;
  logic                  unused_int_bit;
  fclass_e               cls;
  dbl_t                  res;

  assign sign           = hi_i[EXT_EXP_W];
  assign exp_in         = hi_i[EXT_EXP_W-1:0];
  assign unused_int_bit = sig_i[EXT_SIG_W-1];
  assign payload_nz     = |sig_i[EXT_SIG_W-2:0];
  assign frac_trunc     = sig_i[EXT_SIG_W-2 -: DBL_FRAC_W];

  // round half up on first dropped bit
  assign frac_rnd = {1'b0, frac_trunc} + {{DBL_FRAC_W{1'b0}}, sig_i[DROP_W-1]};

  // re-bias after rounding carry; signed in CALC_W bits
  assign exp_adj  = {2'b00, exp_in} - CALC_W'(BIAS_DELTA)
                  + {{(CALC_W-1){1'b0}}, frac_rnd[DBL_FRAC_W]};
  assign adj_neg  = exp_adj[CALC_W-1];
  assign adj_zero = (exp_adj == '0);
  assign adj_ovf  = !adj_neg && (exp_adj >= CALC_W'(DBL_EXP_MAX));

  always_comb begin
    if (exp_in == EXT_EXP_W'(EXT_EXP_MAX))
      cls = payload_nz ? FC_NAN : FC_INF;
    else if (exp_in == '0)
      cls = FC_ZERO;
    else
      cls = FC_FINITE;
  end

  always_comb begin
    res.sign = sign;
    res.exp  = '0;
    res.frac = '0;
    unique case (cls)
      FC_ZERO: ;
      FC_INF: res.exp = DBL_EXP_W'(DBL_EXP_MAX);
      FC_NAN: begin
        res.exp  = DBL_EXP_W'(DBL_EXP_MAX);
        res.frac = (frac_trunc == '0) ? DBL_FRAC_W'(1) : frac_trunc;
      end
      FC_FINITE: begin
        if (adj_neg || adj_zero) begin
          res.exp = '0;
        end else if (adj_ovf) begin
          res.exp = DBL_EXP_W'(DBL_EXP_MAX);
        end else begin
          res.exp  = exp_adj[DBL_EXP_W-1:0];
          res.frac = frac_rnd[DBL_FRAC_W-1:0];
        end
      end
      default: ;
    endcase
  end

  cvt_pipe #(.W(DBL_W)) u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (res),
    .valid_o (valid_o),
    .data_o  (dbl_o)
  );

  AST_NAR_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i)); // R1
  AST_NAR_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> dbl_o[DBL_W-1] == $past(hi_i[EXT_EXP_W])); // R2
  AST_NAR_INF_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && dbl_o[DBL_W-2 -: DBL_EXP_W] == DBL_EXP_W'(DBL_EXP_MAX)
     && $past(hi_i[EXT_EXP_W-1:0]) != EXT_EXP_W'(EXT_EXP_MAX))
    |-> dbl_o[DBL_FRAC_W-1:0] == '0); // R4
  AST_NAR_ZERO_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(hi_i[EXT_EXP_W-1:0]) == '0) |-> dbl_o[DBL_W-2:0] == '0); // R5
  AST_NAR_NAN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(hi_i[EXT_EXP_W-1:0]) == EXT_EXP_W'(EXT_EXP_MAX)
     && $past(sig_i[EXT_SIG_W-2:0]) != '0) |-> dbl_o[DBL_FRAC_W-1:0] != '0); // R6
endmodule

// File: rtl/dbl_to_ext.sv
module dbl_to_ext
  import cvt_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [DBL_W-1:0]     dbl_i,
  output logic                 valid_o,
  output logic [EXT_SIG_W-1:0] sig_o,
  output logic [EXT_HI_W-1:0]  hi_o
);
  localparam int OUT_W = EXT_HI_W + EXT_SIG_W;

  dbl_t                 din;
  fclass_e              cls;
  ext_hi_t              res_hi;
  logic [EXT_SIG_W-1:0] res_sig;
  logic [OUT_W-1:0]     pipe_q;

  assign din = dbl_i;

  always_comb begin
    if (din.exp == DBL_EXP_W'(DBL_EXP_MAX))
      cls = (din.frac != '0) ? FC_NAN : FC_INF;
    else if (din.exp == '0)
      cls = FC_ZERO; // denormals flush
    else
      cls = FC_FINITE;
  end

  always_comb begin
    res_hi.sign = din.sign;
    res_hi.exp  = '0;
    res_sig     = '0;
    unique case (cls)
      FC_ZERO: ;
      FC_INF, FC_NAN: begin
        res_hi.exp = EXT_EXP_W'(EXT_EXP_MAX);
        res_sig    = {1'b1, din.frac, {DROP_W{1'b0}}};
      end
      FC_FINITE: begin
        res_hi.exp = EXT_EXP_W'(din.exp) + EXT_EXP_W'(BIAS_DELTA);
        res_sig    = {1'b1, din.frac, {DROP_W{1'b0}}};
      end
      default: ;
    endcase
  end

  cvt_pipe #(.W(OUT_W)) u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  ({res_hi, res_sig}),
    .valid_o (valid_o),
    .data_o  (pipe_q)
  );

  assign hi_o  = pipe_q[OUT_W-1 -: EXT_HI_W];
  assign sig_o = pipe_q[EXT_SIG_W-1:0];

  AST_WID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i)); // R1
  AST_WID_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> sig_o[DROP_W-1:0] == '0); // R7
  AST_WID_INT_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && hi_o[EXT_EXP_W-1:0] != '0) |-> sig_o[EXT_SIG_W-1]); // R7
  AST_WID_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(dbl_i[DBL_W-2 -: DBL_EXP_W]) == '0)
    |-> (sig_o == '0 && hi_o[EXT_EXP_W-1:0] == '0)); // R8
  AST_WID_SPECIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(dbl_i[DBL_W-2 -: DBL_EXP_W]) == DBL_EXP_W'(DBL_EXP_MAX))
    |-> hi_o[EXT_EXP_W-1:0] == EXT_EXP_W'(EXT_EXP_MAX)); // R9
endmodule

// File: rtl/ext_dbl_cvt.sv
module ext_dbl_cvt
  import cvt_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 nar_valid_i,
  input  logic [EXT_SIG_W-1:0] nar_sig_i,
  input  logic [EXT_HI_W-1:0]  nar_hi_i,
  output logic                 nar_valid_o,
  output logic [DBL_W-1:0]     nar_dbl_o,
  input  logic                 wid_valid_i,
  input  logic [DBL_W-1:0]     wid_dbl_i,
  output logic                 wid_valid_o,
  output logic [EXT_SIG_W-1:0] wid_sig_o,
  output logic [EXT_HI_W-1:0]  wid_hi_o
);
  ext_to_dbl u_nar (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (nar_valid_i),
    .sig_i   (nar_sig_i),
    .hi_i    (nar_hi_i),
    .valid_o (nar_valid_o),
    .dbl_o   (nar_dbl_o)
  );

  dbl_to_ext u_wid (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (wid_valid_i),
    .dbl_i   (wid_dbl_i),
    .valid_o (wid_valid_o),
    .sig_o   (wid_sig_o),
    .hi_o    (wid_hi_o)
  );
endmodule

// File: tb/ext_dbl_cvt_test.sv
module ext_dbl_cvt_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        nar_valid_i = 1'b0;
  logic [63:0] nar_sig_i = '0;
  logic [15:0] nar_hi_i = '0;
  logic        nar_valid_o;
  logic [63:0] nar_dbl_o;
  logic        wid_valid_i = 1'b0;
  logic [63:0] wid_dbl_i = '0;
  logic        wid_valid_o;
  logic [63:0] wid_sig_o;
  logic [15:0] wid_hi_o;

  int checks = 0;
  int errors = 0;

  logic [63:0] nar_q[$];
  string       nar_tag_q[$];
  logic [79:0] wid_q[$];
  string       wid_tag_q[$];

  ext_dbl_cvt uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .nar_valid_i (nar_valid_i),
    .nar_sig_i   (nar_sig_i),
    .nar_hi_i    (nar_hi_i),
    .nar_valid_o (nar_valid_o),
    .nar_dbl_o   (nar_dbl_o),
    .wid_valid_i (wid_valid_i),
    .wid_dbl_i   (wid_dbl_i),
    .wid_valid_o (wid_valid_o),
    .wid_sig_o   (wid_sig_o),
    .wid_hi_o    (wid_hi_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [63:0] model_nar(input logic [15:0] hi, input logic [63:0] sig);
    int e;
    int d;
    logic s;
    longint unsigned f;
    e = int'(hi[14:0]);
    s = hi[15];
    if (e == 32767) begin
      if (sig[62:0] == 63'h0) return {s, 11'h7FF, 52'h0};
      f = longint'(sig[62:11]);
      if (f == 0) f = 1;
      return {s, 11'h7FF, f[51:0]};
    end
    if (e == 0) return {s, 63'h0};
    d = e - 16383 + 1023;
    f = longint'(sig[62:11]) + longint'(sig[10]);
    if (f == 64'h0010_0000_0000_0000) begin
      f = 0;
      d = d + 1;
    end
    if (d >= 2047) return {s, 11'h7FF, 52'h0};
    if (d <= 0) return {s, 63'h0};
    return {s, d[10:0], f[51:0]};
  endfunction

  function automatic logic [79:0] model_wid(input logic [63:0] dbl);
    int de;
    de = int'(dbl[62:52]);
    if (de == 0) return {dbl[63], 15'h0, 64'h0};
    if (de == 2047) return {dbl[63], 15'h7FFF, 1'b1, dbl[51:0], 11'h0};
    de = de - 1023 + 16383;
    return {dbl[63], de[14:0], 1'b1, dbl[51:0], 11'h0};
  endfunction

  task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_nar(input logic [15:0] hi, input logic [63:0] sig, input string tag);
    nar_valid_i = 1'b1;
    nar_hi_i    = hi;
    nar_sig_i   = sig;
    nar_q.push_back(model_nar(hi, sig));
    nar_tag_q.push_back(tag);
    @(negedge clk_i);
    nar_valid_i = 1'b0;
  endtask

  task automatic send_wid(input logic [63:0] dbl, input string tag);
    wid_valid_i = 1'b1;
    wid_dbl_i   = dbl;
    wid_q.push_back(model_wid(dbl));
    wid_tag_q.push_back(tag);
    @(negedge clk_i);
    wid_valid_i = 1'b0;
  endtask

  task automatic send_both(input logic [15:0] hi, input logic [63:0] sig,
                           input logic [63:0] dbl);
    nar_valid_i = 1'b1;
    nar_hi_i    = hi;
    nar_sig_i   = sig;
    wid_valid_i = 1'b1;
    wid_dbl_i   = dbl;
    nar_q.push_back(model_nar(hi, sig));
    nar_tag_q.push_back("R10 concurrent narrow");
    wid_q.push_back(model_wid(dbl));
    wid_tag_q.push_back("R10 concurrent widen");
    @(negedge clk_i);
    nar_valid_i = 1'b0;
    wid_valid_i = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (nar_valid_o) begin
        if (nar_q.size() == 0) begin
          check("R1 unexpected narrow valid", 80'(nar_valid_o), 80'(0));
        end else begin
          check(nar_tag_q.pop_front(), 80'(nar_dbl_o), 80'(nar_q.pop_front()));
        end
      end
      if (wid_valid_o) begin
        if (wid_q.size() == 0) begin
          check("R1 unexpected widen valid", 80'(wid_valid_o), 80'(0));
        end else begin
          check(wid_tag_q.pop_front(), {wid_hi_o, wid_sig_o}, wid_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint unsigned rs;
    rs = 64'h9E37_79B9_7F4A_7C15;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 reset narrow", {15'h0, nar_valid_o, nar_dbl_o}, 80'h0);
    check("R1 reset widen valid", 80'(wid_valid_o), 80'h0);
    check("R1 reset widen data", {wid_hi_o, wid_sig_o}, 80'h0);

    // R2 plain narrowing
    send_nar(16'h3FFF, 64'h8000_0000_0000_0000, "R2 one");
    send_nar(16'hC000, 64'hA000_0000_0000_0000, "R2 minus 2.5");
    send_nar(16'h3FFF, 64'h8000_0000_0000_03FF, "R2 truncate");
    send_nar(16'h43FE, 64'hFFFF_FFFF_FFFF_F800, "R2 max finite");
    // R3 rounding
    send_nar(16'h3FFF, 64'h8000_0000_0000_0400, "R3 round lsb");
    send_nar(16'h3FFF, 64'hFFFF_FFFF_FFFF_FC00, "R3 carry into exponent");
    // R4 overflow
    send_nar(16'h43FE, 64'hFFFF_FFFF_FFFF_FC00, "R4 carry into max exponent");
    send_nar(16'h43FF, 64'h8000_0000_0000_0000, "R4 exponent 2047");
    send_nar(16'hC400, 64'hC000_0000_0000_0000, "R4 negative overflow");
    // R5 underflow and zero
    send_nar(16'h3C00, 64'h8000_0000_0000_0000, "R5 rebias zero");
    send_nar(16'hBC00, 64'hFFFF_0000_0000_0000, "R5 negative flush");
    send_nar(16'h3C01, 64'h8000_0000_0000_0000, "R5 smallest kept");
    send_nar(16'h8000, 64'h0, "R5 negative zero");
    send_nar(16'h0001, 64'h8000_0000_0000_0000, "R5 far below range");
    // R6 special
    send_nar(16'h7FFF, 64'h8000_0000_0000_0000, "R6 infinity");
    send_nar(16'hFFFF, 64'hC000_0000_0000_0000, "R6 quiet nan");
    send_nar(16'h7FFF, 64'h8000_0000_0000_0001, "R6 low payload nan");
    send_nar(16'h7FFF, 64'hC000_0000_0000_0400, "R6 nan no rounding");

    // R7 widening
    send_wid(64'h3FF0_0000_0000_0000, "R7 one");
    send_wid(64'hC004_0000_0000_0000, "R7 minus 2.5");
    send_wid(64'h7FEF_FFFF_FFFF_FFFF, "R7 max finite");
    send_wid(64'h0010_0000_0000_0000, "R7 min normal");
    // R8 zero / denormal
    send_wid(64'h0000_0000_0000_0000, "R8 zero");
    send_wid(64'h8000_0000_0000_0000, "R8 negative zero");
    send_wid(64'h0000_0000_0000_0001, "R8 denormal flush");
    // R9 special
    send_wid(64'hFFF0_0000_0000_0000, "R9 negative infinity");
    send_wid(64'h7FF0_0000_0000_0001, "R9 nan payload");

    // R10 both directions together, back to back
    send_both(16'h4000, 64'hC000_0000_0000_0400, 64'h4008_0000_0000_0000);
    send_both(16'h7FFF, 64'h8000_0000_0000_0010, 64'h0000_0000_0000_0000);

    // R1 hold: inputs change with valid low
    repeat (2) @(negedge clk_i);
    nar_hi_i  = 16'h1234;
    nar_sig_i = 64'hDEAD_BEEF_0000_0000;
    wid_dbl_i = 64'h1234_5678_9ABC_DEF0;
    repeat (2) @(negedge clk_i);
    check("R1 narrow hold", {15'h0, nar_valid_o, nar_dbl_o},
          {15'h0, 1'b0, model_nar(16'h7FFF, 64'h8000_0000_0000_0010)});
    check("R1 widen hold", {wid_hi_o, wid_sig_o}, model_wid(64'h0));
    check("R1 widen valid low", 80'(wid_valid_o), 80'h0);

    // random sweep around the range edges (R2 R3 R4 R5 R7)
    for (int i = 0; i < 60; i++) begin
      logic [15:0] h;
      rs = rs ^ (rs << 13);
      rs = rs ^ (rs >> 7);
      rs = rs ^ (rs << 17);
      h = {rs[63], 15'(15350 + int'(rs[11:0] % 12'd2060))};
      send_nar(h, {1'b1, rs[62:0]}, "R3 random narrow");
      send_wid(rs ^ 64'h5555_0000_AAAA_0000, "R7 random widen");
    end

    repeat (4) @(negedge clk_i);
    check("R1 narrow queue drained", 80'(nar_q.size()), 80'h0);
    check("R1 widen queue drained", 80'(wid_q.size()), 80'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule